// File: doc/BRIEF.md
# Packed Float Compare Mask Unit

This block compares IEEE-754 single-precision values lane by lane and produces a bit mask for each lane. It takes two 128-bit sources, each holding four 32-bit floats. A 3-bit predicate selects the relation. Each result lane is either all ones, when the relation holds, or all zeros when it does not. Downstream logic can use the result directly as a select mask for blends or bitwise operations.

There are two modes. In packed mode all four lanes are compared independently under the same predicate. In scalar mode only lane 0 is compared, and the upper three result lanes carry the first source's upper lanes unchanged.

The result and its valid flag are registered. A small two-state output machine holds the valid flag:

- ST_IDLE means no result was produced on the last edge.
- ST_PRESENT means the registered mask was written on the last edge.

The machine moves as follows:

- ST_IDLE goes to ST_PRESENT when the request strobe is high.
- ST_PRESENT stays in ST_PRESENT while the strobe stays high.
- ST_PRESENT returns to ST_IDLE when the strobe is low.

Top module: `fcmp_mask_unit`

## Requirements
- R1: The 3-bit predicate selects the relation: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered.
- R2: Every compared lane of the result is 32'hFFFFFFFF when its relation holds and 32'h00000000 otherwise.
- R3: A value is NaN when its exponent field (bits 30:23) is all ones and its mantissa (bits 22:0) is nonzero, whether quiet or signalling. Unordered holds when either operand is NaN, and ordered holds when neither is. Infinity is not NaN.
- R4: Equal, less-than and less-or-equal are false when either operand is NaN. Not-equal, not-less-than and not-less-or-equal are true when either operand is NaN.
- R5: +0 (32'h00000000) and -0 (32'h80000000) compare as equal.
- R6: Non-NaN values are ordered by sign and then magnitude. Among two negatives the larger magnitude is the smaller value. Infinities order below or above every finite value.
- R7: In packed mode (scalar flag 0), each of the four 32-bit lanes (lane n at bits 32n+31:32n) is compared independently under the one predicate.
- R8: In scalar mode (scalar flag 1), only lane 0 is compared, and result bits 127:32 equal the first source's bits 127:32.
- R9: The mask and the valid output are registered. The valid output is high exactly one cycle after a request strobe. The mask changes only on an edge with the strobe high and holds otherwise.
- R10: While reset is high, the mask clears to zero and the valid output is low on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Request strobe; operands are captured on this edge |
| scalar_i | input | 1 | 1 = compare lane 0 only, 0 = compare all lanes |
| pred_i | input | 3 | Compare predicate code |
| src_a_i | input | 128 | First source, four float lanes |
| src_b_i | input | 128 | Second source, four float lanes |
| rsp_valid_o | output | 1 | Registered result valid |
| mask_o | output | 128 | Registered lane mask result |

## Verification
The bench builds the unit with its default parameters: four lanes, an 8-bit exponent and a 23-bit mantissa. This is the full 32-bit single-precision lane format. With those values the stimulus can use exact encodings of signed zeros, infinities, and quiet and signalling NaNs. Every predicate code can be paired with the lane-specific corner that distinguishes it from its complement. Back-to-back strobes, idle cycles with changing operands, and a mid-run reset exercise both transitions out of each output state.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [2:0] {
        PRED_EQ    = 3'd0,
        PRED_LT    = 3'd1,
        PRED_LE    = 3'd2,
        PRED_UNORD = 3'd3,
        PRED_NE    = 3'd4,
        PRED_NLT   = 3'd5,
        PRED_NLE   = 3'd6,
        PRED_ORD   = 3'd7
    } cmp_pred_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } out_state_e;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              nan_o,
    output logic              zero_o,
    output logic              sign_o,
    output logic [WORD_W-2:0] mag_o
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    always_comb begin
        sign_o = word_i[WORD_W-1];
        mag_o  = word_i[WORD_W-2:0];
        exp_f  = word_i[WORD_W-2:MAN_W];
        man_f  = word_i[MAN_W-1:0];
        nan_o  = (&exp_f) && (|man_f);
        zero_o = (mag_o == '0);
    end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int MAG_W = 31
) (
    input  logic             a_nan_i,
    input  logic             a_zero_i,
    input  logic             a_sign_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             b_nan_i,
    input  logic             b_zero_i,
    input  logic             b_sign_i,
    input  logic [MAG_W-1:0] b_mag_i,
    output logic             eq_o,
    output logic             lt_o,
    output logic             unord_o
);

    logic both_zero;

    always_comb begin
        both_zero = a_zero_i && b_zero_i;
        unord_o   = a_nan_i || b_nan_i;
        eq_o      = both_zero || ((a_sign_i == b_sign_i) && (a_mag_i == b_mag_i));
        if (both_zero) begin
            lt_o = 1'b0;
        end else if (a_sign_i != b_sign_i) begin
            lt_o = a_sign_i;
        end else if (a_sign_i) begin
            lt_o = (a_mag_i > b_mag_i);
        end else begin
            lt_o = (a_mag_i < b_mag_i);
        end
    end

endmodule

// File: rtl/fcmp_pred_sel.sv
module fcmp_pred_sel
    import fcmp_pkg::*;
(
    input  logic [2:0] pred_i,
    input  logic       eq_i,
    input  logic       lt_i,
    input  logic       unord_i,
    output logic       hit_o
);

    cmp_pred_e pred;

    always_comb begin
        pred = cmp_pred_e'(pred_i);
        unique case (pred)
            PRED_EQ:    hit_o = eq_i && !unord_i;
            PRED_LT:    hit_o = lt_i && !unord_i;
            PRED_LE:    hit_o = (lt_i || eq_i) && !unord_i;
            PRED_UNORD: hit_o = unord_i;
            PRED_NE:    hit_o = !eq_i || unord_i;
            PRED_NLT:   hit_o = !lt_i || unord_i;
            PRED_NLE:   hit_o = !(lt_i || eq_i) || unord_i;
            PRED_ORD:   hit_o = !unord_i;
            default:    hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fcmp_mask_unit.sv
module fcmp_mask_unit
    import fcmp_pkg::*;
#(
    parameter int LANES = 4,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int LANE_W = 1 + EXP_W + MAN_W,
    localparam int BUS_W  = LANES * LANE_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             req_valid_i,
    input  logic             scalar_i,
    input  logic [2:0]       pred_i,
    input  logic [BUS_W-1:0] src_a_i,
    input  logic [BUS_W-1:0] src_b_i,
    output logic             rsp_valid_o,
    output logic [BUS_W-1:0] mask_o
);

    localparam int MAG_W = LANE_W - 1;

    out_state_e       state_q;
    out_state_e       state_d;
    logic [BUS_W-1:0] mask_d;
    logic [BUS_W-1:0] mask_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] a_w;
        logic [LANE_W-1:0] b_w;
        logic              a_nan, a_zero, a_sign;
        logic              b_nan, b_zero, b_sign;
        logic [MAG_W-1:0]  a_mag, b_mag;
        logic              eq, lt, unord, hit;

        assign a_w = src_a_i[l*LANE_W +: LANE_W];
        assign b_w = src_b_i[l*LANE_W +: LANE_W];

        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
            .word_i (a_w),
            .nan_o  (a_nan),
            .zero_o (a_zero),
            .sign_o (a_sign),
            .mag_o  (a_mag)
        );

        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
            .word_i (b_w),
            .nan_o  (b_nan),
            .zero_o (b_zero),
            .sign_o (b_sign),
            .mag_o  (b_mag)
        );

        fcmp_order #(.MAG_W(MAG_W)) u_order (
            .a_nan_i  (a_nan),
            .a_zero_i (a_zero),
            .a_sign_i (a_sign),
            .a_mag_i  (a_mag),
            .b_nan_i  (b_nan),
            .b_zero_i (b_zero),
            .b_sign_i (b_sign),
            .b_mag_i  (b_mag),
            .eq_o     (eq),
            .lt_o     (lt),
            .unord_o  (unord)
        );

        fcmp_pred_sel u_pred (
            .pred_i  (pred_i),
            .eq_i    (eq),
            .lt_i    (lt),
            .unord_i (unord),
            .hit_o   (hit)
        );

        if (l == 0) begin : g_head
            assign mask_d[l*LANE_W +: LANE_W] = {LANE_W{hit}};
        end else begin : g_tail
            assign mask_d[l*LANE_W +: LANE_W] = scalar_i ? a_w : {LANE_W{hit}};
        end
    end

    // Next-state selection for the output machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = req_valid_i ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = req_valid_i ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q <= '0;
        end else if (req_valid_i) begin
            mask_q <= mask_d;
        end
    end

    assign rsp_valid_o = (state_q == ST_PRESENT);
    assign mask_o      = mask_q;

endmodule

// File: rtl/fcmp_mask_unit_chk.sv
module fcmp_mask_unit_chk #(
    parameter int LANES = 4,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int LANE_W = 1 + EXP_W + MAN_W,
    localparam int BUS_W  = LANES * LANE_W
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             req_valid_i,
    input logic             scalar_i,
    input logic [2:0]       pred_i,
    input logic [BUS_W-1:0] src_a_i,
    input logic [BUS_W-1:0] src_b_i,
    input logic             rsp_valid_o,
    input logic [BUS_W-1:0] mask_o
);

    assert_reset_clear_R10: assert property (@(posedge clk_i)
        rst_i |=> (!rsp_valid_o && mask_o == '0));

    assert_valid_rise_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        req_valid_i |=> rsp_valid_o);

    assert_valid_drop_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |=> !rsp_valid_o);

    assert_mask_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |=> $stable(mask_o));

    assert_scalar_pass_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && scalar_i) |=> (mask_o[BUS_W-1:LANE_W] == $past(src_a_i[BUS_W-1:LANE_W])));

    assert_signed_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && pred_i == 3'd0 && src_a_i[LANE_W-2:0] == '0 && src_b_i[LANE_W-2:0] == '0)
        |=> (mask_o[LANE_W-1:0] == '1));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        assert_full_lane_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            (req_valid_i && !scalar_i) |=>
            (mask_o[l*LANE_W +: LANE_W] == '0 || mask_o[l*LANE_W +: LANE_W] == '1));
    end

endmodule

bind fcmp_mask_unit fcmp_mask_unit_chk #(
    .LANES (LANES),
    .EXP_W (EXP_W),
    .MAN_W (MAN_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_valid_i (req_valid_i),
    .scalar_i    (scalar_i),
    .pred_i      (pred_i),
    .src_a_i     (src_a_i),
    .src_b_i     (src_b_i),
    .rsp_valid_o (rsp_valid_o),
    .mask_o      (mask_o)
);

// File: tb/fcmp_mask_unit_tb_top.sv
`timescale 1ns/1ps
module fcmp_mask_unit_tb_top;

    localparam logic [31:0] P1   = 32'h3F800000;
    localparam logic [31:0] P2   = 32'h40000000;
    localparam logic [31:0] N1   = 32'hBF800000;
    localparam logic [31:0] N2   = 32'hC0000000;
    localparam logic [31:0] PZ   = 32'h00000000;
    localparam logic [31:0] NZ   = 32'h80000000;
    localparam logic [31:0] QN   = 32'h7FC00000;
    localparam logic [31:0] SN   = 32'h7F800001;
    localparam logic [31:0] INF  = 32'h7F800000;
    localparam logic [31:0] NINF = 32'hFF800000;
    localparam logic [31:0] T    = 32'hFFFFFFFF;
    localparam logic [31:0] F    = 32'h00000000;
    localparam logic [31:0] A3   = 32'h12345678;
    localparam logic [31:0] A2   = 32'h9ABCDEF0;
    localparam logic [31:0] A1   = 32'h0F0F0F0F;

    typedef struct packed {
        logic [2:0]   pred;
        logic         scal;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
    } vec_t;

    localparam int NV = 12;

    // lanes written {lane3, lane2, lane1, lane0}
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, {P1, P2, PZ, QN},   {P1, P1, NZ, QN},    {T, F, T, F}},
        '{3'd1, 1'b0, {P1, N2, N1, INF},  {P2, N1, P1, SN},    {T, T, T, F}},
        '{3'd2, 1'b0, {P2, N1, PZ, QN},   {P1, N1, NZ, P1},    {F, T, T, F}},
        '{3'd3, 1'b0, {QN, P1, INF, SN},  {P1, P1, INF, P1},   {T, F, F, T}},
        '{3'd4, 1'b0, {P1, PZ, QN, P2},   {P1, NZ, QN, P1},    {F, F, T, T}},
        '{3'd5, 1'b0, {P1, N1, QN, N2},   {P2, N2, P1, N2},    {F, T, T, T}},
        '{3'd6, 1'b0, {P2, N2, NINF, P1}, {P1, N1, SN, P1},    {T, F, T, F}},
        '{3'd7, 1'b0, {P1, QN, INF, NZ},  {P2, P1, SN, P1},    {T, F, F, T}},
        '{3'd1, 1'b1, {A3, A2, A1, N1},   {T, T, T, P1},       {A3, A2, A1, T}},
        '{3'd4, 1'b1, {A3, A2, A1, QN},   {F, F, F, QN},       {A3, A2, A1, T}},
        '{3'd0, 1'b1, {A1, A3, A2, PZ},   {P1, P1, P1, NZ},    {A1, A3, A2, T}},
        '{3'd1, 1'b0, {NINF, P1, INF, N1},{INF, INF, P2, NINF},{T, T, F, F}}
    };

    localparam string TAGS [NV] = '{
        "R1 R3 R5 equal", "R1 R4 R6 less-than", "R1 R5 R6 less-or-equal",
        "R1 R3 unordered", "R1 R4 R5 not-equal", "R1 R4 R6 not-less-than",
        "R1 R4 R6 not-less-or-equal", "R3 R7 ordered", "R8 scalar lt",
        "R8 R4 scalar ne NaN", "R8 R5 scalar eq zeros", "R2 R6 R7 infinities"
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         scal = 1'b0;
    logic [2:0]   pred = 3'd0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         rsp_valid;
    logic [127:0] mask;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fcmp_mask_unit dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .req_valid_i (req_valid),
        .scalar_i    (scal),
        .pred_i      (pred),
        .src_a_i     (src_a),
        .src_b_i     (src_b),
        .rsp_valid_o (rsp_valid),
        .mask_o      (mask)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] last;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset mask", mask, '0);
        chk("R10 reset valid", {127'b0, rsp_valid}, '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 idle valid low", {127'b0, rsp_valid}, '0);

        // table walk with back-to-back strobes
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            pred      = VECS[i].pred;
            scal      = VECS[i].scal;
            src_a     = VECS[i].a;
            src_b     = VECS[i].b;
            @(posedge clk);
            #1;
            chk({TAGS[i], " R9 valid"}, {127'b0, rsp_valid}, 128'd1);
            chk(TAGS[i], mask, VECS[i].exp);
        end
        last = VECS[NV-1].exp;

        // hold: strobe low, operands change, mask must not move
        @(negedge clk);
        req_valid = 1'b0;
        pred      = 3'd4;
        scal      = 1'b0;
        src_a     = {P1, P1, P1, P1};
        src_b     = {P2, P2, P2, P2};
        @(posedge clk);
        #1;
        chk("R9 valid drops", {127'b0, rsp_valid}, '0);
        chk("R9 mask holds", mask, last);
        @(posedge clk);
        #1;
        chk("R9 mask still holds", mask, last);

        // isolated strobe: valid is high for one cycle only
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #0;
        chk("R9 R4 single strobe valid", {127'b0, rsp_valid}, 128'd1);
        chk("R7 all lanes ne", mask, {T, T, T, T});
        @(posedge clk);
        #1;
        chk("R9 single strobe ends", {127'b0, rsp_valid}, '0);

        // mid-run reset clears mask
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 mid reset mask", mask, '0);
        chk("R10 mid reset valid", {127'b0, rsp_valid}, '0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule